// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block decides whether a received CAN frame header should be kept. Each header (identifier, IDE bit, RTR bit, plus the number of the controller that received it) is packed into a single 32-bit comparison word. That word is checked in parallel against a set of programmable filter banks. Each bank holds two 32-bit words and works in one of two modes:

- **Mask mode:** the first word is a reference value and the second is a care-mask.
- **List mode:** both words are exact identifier words to accept.

The banks are shared between two controllers. Every bank numbered below a programmable split value serves controller 0, and every bank at or above it serves controller 1. When several banks match, the lowest-numbered active bank wins. The block then reports a hit flag, the winning bank number and the receive FIFO assigned to that bank.

Filter storage is written through a single-cycle write port. A header-valid strobe presents a header, and the verdict appears on registered outputs one clock later. The receive path upstream (bit timing, CRC) and the FIFOs downstream sit outside this block.

Top module: `can_accept_filter`

## Requirements
- R1: A standard header (IDE=0) packs as: identifier bits 10:0 in word bits 31:21, zeros in bits 20:3, 0 in bit 2, RTR in bit 1, and 0 in bit 0.
- R2: An extended header (IDE=1) packs as: identifier bits 28:0 in word bits 31:3, 1 in bit 2, RTR in bit 1, and 0 in bit 0.
- R3: In mask mode (mode bit 0), a bank matches when the header word equals word A in every bit position where word B holds a 1. Positions where B holds 0 are ignored.
- R4: In list mode (mode bit 1), a bank matches only when the header word equals word A or word B exactly, including the IDE and RTR bits.
- R5: After reset, only bank 0 is active. It is in mask mode with both words zero and routes to FIFO 0, so it accepts every controller-0 header. All other banks are inactive, both words of every bank are zero, and the split value is 14.
- R6: A header from controller 0 (hdr_ctrl=0) is checked only against banks whose number is below the split value. A header from controller 1 is checked only against banks at or above it. A split value above the bank count gives every bank to controller 0.
- R7: An inactive bank never produces a match.
- R8: When several eligible banks match, the lowest-numbered one is reported, together with its FIFO bit. On a miss, the index and FIFO outputs read 0.
- R9: `match_valid` is high exactly one cycle after each cycle with `hdr_valid` high and low otherwise. Hit, index and FIFO change only in the cycle after a strobe and hold their values in between.
- R10: A register write in the same cycle as a strobe does not affect that header's verdict. It does affect every later header.
- R11: Write address map:
  - Address 2b is word A of bank b; address 2b+1 is word B.
  - Address 56 holds the active bits, one per bank in bit b.
  - Address 57 holds the mode bits (1 = list mode).
  - Address 58 holds the FIFO bits.
  - Address 59 holds the split value in bits 4:0.
  - Writes to addresses 60 to 63 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_ctrl | input | 1 | Receiving controller (0 or 1) |
| hdr_ide | input | 1 | Header IDE bit (1 = extended) |
| hdr_rtr | input | 1 | Header RTR bit |
| hdr_id | input | 29 | Identifier (standard uses bits 10:0) |
| match_valid | output | 1 | Verdict valid |
| match_hit | output | 1 | Header accepted |
| match_index | output | 5 | Winning bank number |
| match_fifo | output | 1 | FIFO of winning bank |

## Verification
The bench aims at the places where a filter silently misroutes frames:

- **IDE and RTR handling.** An extended header whose top bits imitate a standard identifier must fail a bank that compares IDE. A design that packed IDE into the wrong bit would report the wrong bank.
- **Priority and controller split.** Overlapping banks check that the lowest one wins. Headers from each controller check that the split, including the values 0 and 31, is honoured. A design that swapped the owner comparison would show banks from the wrong half.
- **Write/strobe collision.** A write landing in the same cycle as a strobe must leave that verdict on the old settings.
- **Address decode and inactive banks.** Writes to unused addresses and an inactive bank programmed to match must leave results unchanged. This catches loose address decoding and a missing activation gate.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int WORD_W   = 32;
  localparam int STD_ID_W = 11;
  localparam int EXT_ID_W = 29;

  typedef struct packed {
    logic [WORD_W-1:0] word_a;  // reference id (mask mode) or first exact id (list mode)
    logic [WORD_W-1:0] word_b;  // care-mask (mask mode) or second exact id (list mode)
  } bank_regs_t;

  typedef enum logic {
    MODE_MASK = 1'b0,
    MODE_LIST = 1'b1
  } filt_mode_e;

  // Build the 32-bit comparison word from a received header.
  function automatic logic [WORD_W-1:0] pack_header(input logic ide, input logic rtr,
                                                    input logic [EXT_ID_W-1:0] id);
    logic [WORD_W-1:0] w;
    if (ide) w = {id, 1'b1, rtr, 1'b0};
    else     w = {id[STD_ID_W-1:0], {(EXT_ID_W-STD_ID_W){1'b0}}, 1'b0, rtr, 1'b0};
    return w;
  endfunction

endpackage

// File: rtl/cfr_regfile.sv
module cfr_regfile
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS     = 28,
  parameter int DEFAULT_SPLIT = 14,
  parameter int ADDR_W        = 6,
  parameter int SPLIT_W       = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output bank_regs_t [NUM_BANKS-1:0]    bank_q,
  output logic [NUM_BANKS-1:0]          act_q,
  output logic [NUM_BANKS-1:0]          list_q,
  output logic [NUM_BANKS-1:0]          fifo_q,
  output logic [SPLIT_W-1:0]            split_q
);

  localparam int CTRL_BASE = 2 * NUM_BANKS;
  localparam logic [ADDR_W-1:0] ADR_ACT   = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] ADR_MODE  = ADDR_W'(CTRL_BASE + 1);
  localparam logic [ADDR_W-1:0] ADR_FIFO  = ADDR_W'(CTRL_BASE + 2);
  localparam logic [ADDR_W-1:0] ADR_SPLIT = ADDR_W'(CTRL_BASE + 3);

  // Per-bank word storage
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(2 * b);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(2 * b + 1);

    bank_regs_t regs_r;
    bank_regs_t regs_nxt;
    logic       we_a;
    logic       we_b;

    assign we_a = wr_en && (wr_addr == ADR_A);
    assign we_b = wr_en && (wr_addr == ADR_B);

    always_comb begin
      regs_nxt = regs_r;
      if (we_a) regs_nxt.word_a = wr_data;
      if (we_b) regs_nxt.word_b = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_r <= '0;
      end else if (we_a || we_b) begin
        regs_r <= regs_nxt;
      end
    end

    assign bank_q[b] = regs_r;
  end

  // Control registers
  logic                 we_act, we_mode, we_fifo, we_split;
  logic [NUM_BANKS-1:0] act_nxt, list_nxt, fifo_nxt;
  logic [SPLIT_W-1:0]   split_nxt;

  assign we_act   = wr_en && (wr_addr == ADR_ACT);
  assign we_mode  = wr_en && (wr_addr == ADR_MODE);
  assign we_fifo  = wr_en && (wr_addr == ADR_FIFO);
  assign we_split = wr_en && (wr_addr == ADR_SPLIT);

  always_comb begin
    act_nxt   = act_q;
    list_nxt  = list_q;
    fifo_nxt  = fifo_q;
    split_nxt = split_q;
    if (we_act)   act_nxt   = wr_data[NUM_BANKS-1:0];
    if (we_mode)  list_nxt  = wr_data[NUM_BANKS-1:0];
    if (we_fifo)  fifo_nxt  = wr_data[NUM_BANKS-1:0];
    if (we_split) split_nxt = wr_data[SPLIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= NUM_BANKS'(1);
      list_q  <= '0;
      fifo_q  <= '0;
      split_q <= SPLIT_W'(DEFAULT_SPLIT);
    end else if (we_act || we_mode || we_fifo || we_split) begin
      act_q   <= act_nxt;
      list_q  <= list_nxt;
      fifo_q  <= fifo_nxt;
      split_q <= split_nxt;
    end
  end

endmodule

// File: rtl/cfr_bank_match.sv
module cfr_bank_match
  import can_filt_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int SPLIT_W  = 5
) (
  input  logic [WORD_W-1:0]  hdr_word,
  input  bank_regs_t         regs,
  input  logic               active,
  input  logic               list_mode,
  input  logic [SPLIT_W-1:0] split,
  input  logic               ctrl,
  output logic               hit
);

  localparam logic [SPLIT_W-1:0] IDX_V = SPLIT_W'(BANK_IDX);

  logic owner_ok;
  logic eq_a, eq_b, mask_ok, cmp_ok;

  // Banks below the split serve controller 0, the rest controller 1.
  assign owner_ok = ctrl ? (IDX_V >= split) : (IDX_V < split);

  assign eq_a    = (hdr_word == regs.word_a);
  assign eq_b    = (hdr_word == regs.word_b);
  assign mask_ok = ~|((hdr_word ^ regs.word_a) & regs.word_b);

  always_comb begin
    if (filt_mode_e'(list_mode) == MODE_LIST) cmp_ok = eq_a | eq_b;
    else                                      cmp_ok = mask_ok;
  end

  assign hit = active & owner_ok & cmp_ok;

endmodule

// File: rtl/cfr_prio_pick.sv
module cfr_prio_pick #(
  parameter int NUM_BANKS = 28,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_BANKS-1:0] hit_vec,
  input  logic [NUM_BANKS-1:0] fifo_vec,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 win_fifo
);

  // Descending scan: the last assignment, from the lowest bank, wins.
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_fifo = 1'b0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hit_vec[b]) begin
        any_hit  = 1'b1;
        win_idx  = IDX_W'(b);
        win_fifo = fifo_vec[b];
      end
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS     = 28,
  parameter int DEFAULT_SPLIT = 14,
  localparam int ADDR_W       = $clog2(2 * NUM_BANKS + 4),
  localparam int IDX_W        = $clog2(NUM_BANKS),
  localparam int SPLIT_W      = $clog2(NUM_BANKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  input  logic                hdr_valid,
  input  logic                hdr_ctrl,
  input  logic                hdr_ide,
  input  logic                hdr_rtr,
  input  logic [EXT_ID_W-1:0] hdr_id,
  output logic                match_valid,
  output logic                match_hit,
  output logic [IDX_W-1:0]    match_index,
  output logic                match_fifo
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Filter storage
  bank_regs_t [NUM_BANKS-1:0] bank_q;
  logic [NUM_BANKS-1:0]       act_q, list_q, fifo_q;
  logic [SPLIT_W-1:0]         split_q;

  cfr_regfile #(
    .NUM_BANKS    (NUM_BANKS),
    .DEFAULT_SPLIT(DEFAULT_SPLIT),
    .ADDR_W       (ADDR_W),
    .SPLIT_W      (SPLIT_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (cfg_wr_en),
    .wr_addr(cfg_addr),
    .wr_data(cfg_wdata),
    .bank_q (bank_q),
    .act_q  (act_q),
    .list_q (list_q),
    .fifo_q (fifo_q),
    .split_q(split_q)
  );

  // Comparison word and parallel bank compare
  logic [WORD_W-1:0]    hdr_word;
  logic [NUM_BANKS-1:0] hit_vec;

  assign hdr_word = pack_header(hdr_ide, hdr_rtr, hdr_id);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    cfr_bank_match #(
      .BANK_IDX(b),
      .SPLIT_W (SPLIT_W)
    ) u_bank (
      .hdr_word (hdr_word),
      .regs     (bank_q[b]),
      .active   (act_q[b]),
      .list_mode(list_q[b]),
      .split    (split_q),
      .ctrl     (hdr_ctrl),
      .hit      (hit_vec[b])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;
  logic             win_fifo;

  cfr_prio_pick #(
    .NUM_BANKS(NUM_BANKS),
    .IDX_W    (IDX_W)
  ) u_pick (
    .hit_vec (hit_vec),
    .fifo_vec(fifo_q),
    .any_hit (any_hit),
    .win_idx (win_idx),
    .win_fifo(win_fifo)
  );

  // Result register: next state, then register with enable
  logic             valid_nxt;
  logic             hit_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic             fifo_nxt;

  always_comb begin
    valid_nxt = hdr_valid;
    hit_nxt   = match_hit;
    idx_nxt   = match_index;
    fifo_nxt  = match_fifo;
    if (hdr_valid) begin
      hit_nxt  = any_hit;
      idx_nxt  = win_idx;
      fifo_nxt = win_fifo;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      match_valid <= 1'b0;
      match_hit   <= 1'b0;
      match_index <= '0;
      match_fifo  <= 1'b0;
    end else begin
      match_valid <= valid_nxt;
      match_hit   <= hit_nxt;
      match_index <= idx_nxt;
      match_fifo  <= fifo_nxt;
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_BANKS = 28,
  parameter int IDX_W     = 5,
  parameter int SPLIT_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hdr_valid,
  input logic                 hdr_ctrl,
  input logic                 match_valid,
  input logic                 match_hit,
  input logic [IDX_W-1:0]     match_index,
  input logic                 match_fifo,
  input logic [NUM_BANKS-1:0] act_q,
  input logic [SPLIT_W-1:0]   split_q
);

  // Settings and controller seen in the strobe cycle
  logic [NUM_BANKS-1:0] act_prev;
  logic [SPLIT_W-1:0]   split_prev;
  logic                 ctrl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev   <= '0;
      split_prev <= '0;
      ctrl_prev  <= 1'b0;
    end else begin
      act_prev   <= act_q;
      split_prev <= split_q;
      ctrl_prev  <= hdr_ctrl;
    end
  end

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> match_valid);  // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !match_valid);  // R9
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(match_hit) && $stable(match_index) && $stable(match_fifo)));  // R9
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && match_hit) |-> (int'(match_index) < NUM_BANKS));  // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !match_hit) |-> (match_index == '0 && !match_fifo));  // R8
  AST_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && match_hit) |-> act_prev[match_index]);  // R7
  AST_OWNER_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && match_hit) |->
      (ctrl_prev ? (int'(match_index) >= int'(split_prev))
                 : (int'(match_index) <  int'(split_prev))));  // R6

endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NUM_BANKS(NUM_BANKS),
  .IDX_W    (IDX_W),
  .SPLIT_W  (SPLIT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hdr_valid  (hdr_valid),
  .hdr_ctrl   (hdr_ctrl),
  .match_valid(match_valid),
  .match_hit  (match_hit),
  .match_index(match_index),
  .match_fifo (match_fifo),
  .act_q      (act_q),
  .split_q    (split_q)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int A_ACT = 56, A_MODE = 57, A_FIFO = 58, A_SPLIT = 59;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hdr_valid = 1'b0, hdr_ctrl = 1'b0, hdr_ide = 1'b0, hdr_rtr = 1'b0;
  logic [28:0] hdr_id = '0;
  logic        match_valid, match_hit, match_fifo;
  logic [4:0]  match_index;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_ctrl(hdr_ctrl),
    .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr), .hdr_id(hdr_id),
    .match_valid(match_valid), .match_hit(match_hit),
    .match_index(match_index), .match_fifo(match_fifo)
  );

  // Word packing per R1 / R2
  function automatic logic [31:0] bpack(input logic ide, input logic rtr, input logic [28:0] id);
    if (ide) return {id, 1'b1, rtr, 1'b0};
    return {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
  endfunction

  // {ctrl, ide, rtr, id[28:0], exp_hit, exp_idx[4:0], exp_fifo}
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 29'h123,      1'b1, 5'd1,  1'b1},  // R3 R8 bank1 beats bank2
    {1'b0, 1'b0, 1'b1, 29'h123,      1'b1, 5'd2,  1'b0},  // R3 RTR compared by bank1
    {1'b0, 1'b0, 1'b0, 29'h127,      1'b1, 5'd2,  1'b0},  // R3 don't-care low id bits
    {1'b0, 1'b0, 1'b0, 29'h133,      1'b0, 5'd0,  1'b0},  // R3 cared bit differs
    {1'b0, 1'b1, 1'b0, 29'h048C0000, 1'b1, 5'd2,  1'b0},  // R1 R2 IDE bit position
    {1'b0, 1'b1, 1'b0, 29'h1ABCDEF,  1'b1, 5'd3,  1'b1},  // R4 list word A
    {1'b0, 1'b1, 1'b1, 29'h1ABCDEF,  1'b0, 5'd0,  1'b0},  // R4 RTR mismatch
    {1'b0, 1'b0, 1'b1, 29'h055,      1'b1, 5'd3,  1'b1},  // R4 list word B
    {1'b0, 1'b0, 1'b0, 29'h055,      1'b0, 5'd0,  1'b0},  // R4 exact only
    {1'b0, 1'b1, 1'b1, 29'h0000001,  1'b1, 5'd5,  1'b0},  // R4 ext remote
    {1'b0, 1'b0, 1'b0, 29'h000,      1'b1, 5'd5,  1'b0},  // R4 zero word
    {1'b0, 1'b0, 1'b0, 29'h300,      1'b0, 5'd0,  1'b0},  // R7 inactive bank4
    {1'b0, 1'b0, 1'b0, 29'h7AB,      1'b0, 5'd0,  1'b0},  // R6 bank20 not for ctrl0
    {1'b1, 1'b0, 1'b0, 29'h7AB,      1'b1, 5'd20, 1'b1},  // R6 R8 ctrl1 bank20
    {1'b1, 1'b1, 1'b1, 29'h1C000000, 1'b1, 5'd20, 1'b1},  // R3 IDE don't-care
    {1'b1, 1'b0, 1'b0, 29'h123,      1'b1, 5'd21, 1'b0},  // R6 bank1 not for ctrl1
    {1'b0, 1'b1, 1'b0, 29'h0000001,  1'b0, 5'd0,  1'b0}   // R4 ext data vs remote entry
  };

  task automatic chk(input string tag, input logic ev, input logic eh,
                     input logic [4:0] ei, input logic ef);
    checks++;
    if (match_valid !== ev || match_hit !== eh || match_index !== ei || match_fifo !== ef) begin
      errors++;
      $display("FAIL %s: got v=%0b hit=%0b idx=%0d fifo=%0b, expected v=%0b hit=%0b idx=%0d fifo=%0b",
               tag, match_valid, match_hit, match_index, match_fifo, ev, eh, ei, ef);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 6'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic drive_hdr(input logic c, input logic i, input logic r, input logic [28:0] id);
    hdr_valid = 1'b1; hdr_ctrl = c; hdr_ide = i; hdr_rtr = r; hdr_id = id;
  endtask

  // One strobe; returns at the negedge after the registering edge.
  task automatic strobe(input logic c, input logic i, input logic r, input logic [28:0] id);
    @(negedge clk);
    drive_hdr(c, i, r, id);
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R5 reset outputs", 1'b0, 1'b0, 5'd0, 1'b0);
    strobe(1'b1, 1'b0, 1'b1, 29'h5A5);
    chk("R5 ctrl1 banks inactive after reset", 1'b1, 1'b0, 5'd0, 1'b0);
    strobe(1'b0, 1'b0, 1'b1, 29'h5A5);
    chk("R5 bank0 accepts std", 1'b1, 1'b1, 5'd0, 1'b0);
    @(negedge clk);
    chk("R9 outputs hold without strobe", 1'b0, 1'b1, 5'd0, 1'b0);
    strobe(1'b0, 1'b1, 1'b0, 29'h1234567);
    chk("R5 bank0 accepts ext", 1'b1, 1'b1, 5'd0, 1'b0);

    // Split edges
    wr(A_SPLIT, 32'd0);
    strobe(1'b1, 1'b0, 1'b0, 29'h011);
    chk("R6 split0 ctrl1 owns bank0", 1'b1, 1'b1, 5'd0, 1'b0);
    strobe(1'b0, 1'b0, 1'b0, 29'h011);
    chk("R6 split0 ctrl0 owns none", 1'b1, 1'b0, 5'd0, 1'b0);
    wr(A_SPLIT, 32'd31);
    strobe(1'b1, 1'b0, 1'b0, 29'h011);
    chk("R6 split31 ctrl1 owns none", 1'b1, 1'b0, 5'd0, 1'b0);
    strobe(1'b0, 1'b0, 1'b0, 29'h011);
    chk("R6 split31 ctrl0 owns bank0", 1'b1, 1'b1, 5'd0, 1'b0);
    wr(A_SPLIT, 32'd14);

    // Table configuration (R11 map)
    wr(2,  bpack(1'b0, 1'b0, 29'h123)); wr(3,  32'hFFE00006);
    wr(4,  32'h24000000);               wr(5,  32'hFF000000);
    wr(6,  bpack(1'b1, 1'b0, 29'h1ABCDEF)); wr(7, bpack(1'b0, 1'b1, 29'h055));
    wr(8,  bpack(1'b0, 1'b0, 29'h300)); wr(9,  bpack(1'b0, 1'b0, 29'h300));
    wr(10, bpack(1'b1, 1'b1, 29'h1));   wr(11, 32'h0);
    wr(40, 32'hE0000000);               wr(41, 32'hE0000000);
    wr(42, 32'h0);                      wr(43, 32'h0);
    wr(A_MODE, 32'h00000038);
    wr(A_FIFO, 32'h0010000A);
    wr(A_ACT,  32'h0030002E);

    // Table walk with back-to-back strobes
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) chk($sformatf("R11 table vector %0d", i - 1), 1'b1,
                     VEC[i-1][6], VEC[i-1][5:1], VEC[i-1][0]);
      if (i < NV) drive_hdr(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:7]);
      else        hdr_valid = 1'b0;
    end

    // Write colliding with a strobe
    @(negedge clk);
    drive_hdr(1'b0, 1'b0, 1'b0, 29'h123);
    cfg_wr_en = 1'b1; cfg_addr = 6'd2; cfg_wdata = bpack(1'b0, 1'b0, 29'h456);
    @(negedge clk);
    hdr_valid = 1'b0; cfg_wr_en = 1'b0;
    chk("R10 same-cycle write uses old bank1", 1'b1, 1'b1, 5'd1, 1'b1);
    strobe(1'b0, 1'b0, 1'b0, 29'h123);
    chk("R10 later header sees new bank1", 1'b1, 1'b1, 5'd2, 1'b0);

    // Unused addresses
    wr(60, 32'hFFFFFFFF);
    wr(63, 32'hFFFFFFFF);
    strobe(1'b0, 1'b0, 1'b0, 29'h300);
    chk("R11 unused address leaves bank4 inactive", 1'b1, 1'b0, 5'd0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0, 29'h7AB);
    chk("R11 unused address leaves fifo", 1'b1, 1'b1, 5'd20, 1'b1);

    // FIFO reassignment
    wr(A_FIFO, 32'h0000000A);
    strobe(1'b1, 1'b0, 1'b0, 29'h7AB);
    chk("R8 fifo bit follows bank", 1'b1, 1'b1, 5'd20, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule